// File: doc/BRIEF.md
# Page Hotness Tracker

This block watches the stream of demand reads and writes headed for slow non-volatile memory and decides when a whole 4 KB page is worth copying into a DRAM cache. It keeps a small fully associative table. Each valid entry follows one recently touched page and records two things: how many line accesses that page has received, and which of its 64 lines have been touched at least once.

Each accepted request names a line address. The low six bits select the 64-byte line inside the page, and the bits above them form the page number. When an access brings its page to both the total-access threshold and the distinct-line threshold, the block emits a single-cycle prefetch request carrying that page number. It then drops the entry, so that page does not trigger a second time. On a miss the block allocates a free entry if one exists; otherwise it evicts the least recently used one. Both thresholds come from configuration inputs and are read on every access.

Top module: `page_hotness_tracker`

## Requirements
- R1: After a synchronous active-low reset, `pf_valid` is 0 and every entry is empty, so a page seen before the reset starts again from no history.
- R2: The page number is `req_line_addr >> 6`, and the line index is `req_line_addr[5:0]`. `pf_page` carries the page number of the triggering access.
- R3: An accepted access triggers when the page's total access count, including this access, is at least `cfg_total_thr` and its distinct-line count, including this access, is at least `cfg_unique_thr`. `pf_valid` is then high for exactly the one cycle after the clock edge that sampled the access. A miss that already meets both thresholds triggers at once.
- R4: Repeated accesses to a line that was already touched raise the total count but not the distinct-line count.
- R5: The total count saturates at 2^CNT_W-1 (255 by default) and does not wrap.
- R6: A triggering access leaves no entry for its page, so the next access to that page starts with a count of 1.
- R7: A miss takes an empty entry if one exists. Otherwise it replaces the least recently used entry, and that entry's history is lost.
- R8: A distinct-line threshold above 64 is never met, so no prefetch is produced. A threshold of exactly 64 is met only once every line has been touched.
- R9: A cycle with `req_valid` low changes no history and produces no prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Demand access present this cycle |
| req_line_addr | input | LINE_ADDR_W (34) | Line address: page number above, line index in bits 5:0 |
| cfg_total_thr | input | CNT_W (8) | Minimum total accesses |
| cfg_unique_thr | input | 8 | Minimum distinct lines touched |
| pf_valid | output | 1 | One-cycle prefetch request |
| pf_page | output | LINE_ADDR_W-6 (28) | Page number to prefetch |

## Verification
The only result this block produces is the registered prefetch pulse. It is due in the cycle right after the edge that samples the triggering access, with no further latency. The bench drives each access half a period before an edge and samples `pf_valid` and `pf_page` one nanosecond after that edge. Each check therefore compares the response to exactly one access and cannot see the one before or after it. History effects such as eviction, invalidation, saturation and reset are observed only through later trigger decisions made at that same fixed offset.

// File: rtl/pht_pkg.sv
// Package: shared constants and the line-count helper for the page hotness tracker.
// Assumes a fixed page geometry of 2**LINE_IDX_W lines per page.
package pht_pkg;
    localparam int LINE_IDX_W = 6;
    localparam int LINES      = 1 << LINE_IDX_W;
    localparam int UNIQ_W     = LINE_IDX_W + 1;
    localparam int UTHR_W     = LINE_IDX_W + 2;

    // Count the touched lines in a page bitmap.
    function automatic logic [UNIQ_W-1:0] count_lines(input logic [LINES-1:0] map);
        logic [UNIQ_W-1:0] n;
        n = '0;
        for (int i = 0; i < LINES; i++) begin
            n = n + UNIQ_W'(map[i]);
        end
        return n;
    endfunction
endpackage

// File: rtl/pht_entry.sv
// Module: one table entry holding a page tag, its saturating access count and
// its touched-line bitmap. The owner computes the next contents; the entry
// stores them when wr_i is high. Assumes wr_i is one-hot across entries.
module pht_entry
    import pht_pkg::*;
#(
    parameter int PAGE_W = 28,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              wr_valid_i,
    input  logic [PAGE_W-1:0] wr_page_i,
    input  logic [CNT_W-1:0]  wr_cnt_i,
    input  logic [LINES-1:0]  wr_map_i,
    output logic              valid_o,
    output logic [PAGE_W-1:0] page_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [LINES-1:0]  map_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Store the new contents on a write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            page_o  <= '0;
            cnt_o   <= '0;
            map_o   <= '0;
        end else if (wr_i) begin
            valid_o <= wr_valid_i;
            page_o  <= wr_page_i;
            cnt_o   <= wr_cnt_i;
            map_o   <= wr_map_i;
        end
    end

    // R5: a saturated entry that is updated for the same page stays saturated.
    assert_cnt_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wr_valid_i && valid_o && wr_page_i == page_o && cnt_o == CNT_MAX)
        |=> (cnt_o == CNT_MAX));
endmodule

// File: rtl/pht_lru.sv
// Module: recency ranks for the table. Every entry holds a distinct rank;
// rank 0 is the most recent and rank ENTRIES-1 marks the victim. Assumes
// ranks start as a permutation (set at reset) and a touch keeps them one.
module pht_lru #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_i,
    input  logic [IDX_W-1:0] touch_idx_i,
    output logic [IDX_W-1:0] victim_idx_o
);
    logic [IDX_W-1:0] rank [ENTRIES];
    logic [ENTRIES-1:0] victim_vec;
    logic [IDX_W-1:0] touched_rank;

    // Look up the rank of the entry being touched.
    always_comb touched_rank = rank[touch_idx_i];

    // Promote the touched entry and age those that were more recent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) rank[i] <= IDX_W'(i);
        end else if (touch_i) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx_i)  rank[i] <= '0;
                else if (rank[i] < touched_rank) rank[i] <= rank[i] + 1'b1;
            end
        end
    end

    // Flag and encode the oldest entry.
    always_comb begin
        victim_idx_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            victim_vec[i] = (rank[i] == IDX_W'(ENTRIES - 1));
            if (victim_vec[i]) victim_idx_o = IDX_W'(i);
        end
    end

    // R7: exactly one entry is oldest at all times.
    assert_single_victim_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(victim_vec) == 1);
endmodule

// File: rtl/page_hotness_tracker.sv
// Module: top of the page hotness tracker. Matches each demand line access
// against the table, updates or allocates an entry, and raises a registered
// prefetch pulse when both thresholds are met. Assumes at most one access
// per cycle, with thresholds read live from the configuration inputs.
module page_hotness_tracker
    import pht_pkg::*;
#(
    parameter int LINE_ADDR_W = 34,
    parameter int ENTRIES     = 16,
    parameter int CNT_W       = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [LINE_ADDR_W-1:0]        req_line_addr,
    input  logic [CNT_W-1:0]              cfg_total_thr,
    input  logic [UTHR_W-1:0]             cfg_unique_thr,
    output logic                          pf_valid,
    output logic [LINE_ADDR_W-LINE_IDX_W-1:0] pf_page
);
    localparam int PAGE_W = LINE_ADDR_W - LINE_IDX_W;
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [PAGE_W-1:0]     req_page;
    logic [LINE_IDX_W-1:0] req_line;
    logic                  ent_valid [ENTRIES];
    logic [PAGE_W-1:0]     ent_page  [ENTRIES];
    logic [CNT_W-1:0]      ent_cnt   [ENTRIES];
    logic [LINES-1:0]      ent_map   [ENTRIES];
    logic [ENTRIES-1:0]    hit_vec;
    logic [ENTRIES-1:0]    ent_wr;
    logic                  hit, has_free;
    logic [IDX_W-1:0]      hit_idx, free_idx, victim_idx, sel_idx;
    logic [CNT_W-1:0]      cur_cnt, new_cnt;
    logic [LINES-1:0]      cur_map, new_map;
    logic [UNIQ_W-1:0]     new_uniq;
    logic                  fire;

    // Split the line address into page number and line index.
    always_comb begin
        req_page = req_line_addr[LINE_ADDR_W-1:LINE_IDX_W];
        req_line = req_line_addr[LINE_IDX_W-1:0];
    end

    // Compare the page tag against every entry and find a free slot.
    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        has_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            hit_vec[i] = ent_valid[i] && (ent_page[i] == req_page);
            if (hit_vec[i]) hit_idx = IDX_W'(i);
            if (!ent_valid[i]) begin
                free_idx = IDX_W'(i);
                has_free = 1'b1;
            end
        end
        hit = |hit_vec;
    end

    // Choose the entry this access updates and form its next history.
    always_comb begin
        sel_idx  = hit ? hit_idx : (has_free ? free_idx : victim_idx);
        cur_cnt  = hit ? ent_cnt[hit_idx] : '0;
        cur_map  = hit ? ent_map[hit_idx] : '0;
        new_cnt  = (cur_cnt == CNT_MAX) ? cur_cnt : cur_cnt + 1'b1;
        new_map  = cur_map | (LINES'(1) << req_line);
        new_uniq = count_lines(new_map);
        fire     = req_valid && (new_cnt >= cfg_total_thr)
                   && ({1'b0, new_uniq} >= cfg_unique_thr);
    end

    // Write enable for the selected entry only.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) ent_wr[i] = req_valid && (sel_idx == IDX_W'(i));
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        pht_entry #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (ent_wr[g]),
            .wr_valid_i (!fire),
            .wr_page_i  (req_page),
            .wr_cnt_i   (new_cnt),
            .wr_map_i   (new_map),
            .valid_o    (ent_valid[g]),
            .page_o     (ent_page[g]),
            .cnt_o      (ent_cnt[g]),
            .map_o      (ent_map[g])
        );
    end

    pht_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
        .clk          (clk),
        .rst_n        (rst_n),
        .touch_i      (req_valid && !fire),
        .touch_idx_i  (sel_idx),
        .victim_idx_o (victim_idx)
    );

    // Register the prefetch request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_page  <= '0;
        end else begin
            pf_valid <= fire;
            pf_page  <= req_page;
        end
    end

    // R3: a prefetch pulse always follows an accepted access.
    assert_pulse_after_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> $past(req_valid));
    // R9: an idle cycle produces no prefetch.
    assert_idle_no_prefetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !pf_valid);
    // R8: an unreachable distinct-line threshold blocks every prefetch.
    assert_unique_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_unique_thr > UTHR_W'(LINES)) |=> !pf_valid);
    // R7: a page tag is held by at most one entry.
    assert_unique_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: tb/tb_page_hotness_tracker.sv
`timescale 1ns/1ps
module tb_page_hotness_tracker;
    localparam int LAW = 34;
    localparam int PW  = LAW - 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [LAW-1:0] req_line_addr = '0;
    logic [7:0] cfg_total_thr = '0;
    logic [7:0] cfg_unique_thr = '0;
    logic pf_valid;
    logic [PW-1:0] pf_page;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    page_hotness_tracker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line_addr(req_line_addr),
        .cfg_total_thr(cfg_total_thr), .cfg_unique_thr(cfg_unique_thr),
        .pf_valid(pf_valid), .pf_page(pf_page)
    );

    typedef struct packed {
        logic          vld;
        logic [PW-1:0] page;
        logic [5:0]    line;
        logic [7:0]    at;
        logic [7:0]    uat;
        logic          exp;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 28'h10, 6'd5, 8'd4, 8'd3, 1'b0, 4'd3},  // R3 first access
        '{1'b1, 28'h10, 6'd5, 8'd4, 8'd3, 1'b0, 4'd4},
        '{1'b1, 28'h10, 6'd5, 8'd4, 8'd3, 1'b0, 4'd4},
        '{1'b1, 28'h10, 6'd5, 8'd4, 8'd3, 1'b0, 4'd4},  // R4 total 4, distinct 1
        '{1'b1, 28'h10, 6'd6, 8'd4, 8'd3, 1'b0, 4'd4},  // distinct 2
        '{1'b0, 28'h10, 6'd7, 8'd4, 8'd3, 1'b0, 4'd9},  // R9 idle, line 7 ignored
        '{1'b1, 28'h10, 6'd5, 8'd4, 8'd3, 1'b0, 4'd4},  // repeat keeps distinct 2
        '{1'b1, 28'h10, 6'd7, 8'd4, 8'd3, 1'b1, 4'd3},  // R3 distinct 3, fires
        '{1'b1, 28'h10, 6'd0, 8'd4, 8'd1, 1'b0, 4'd6},  // R6 history restarted
        '{1'b1, 28'h20, 6'd1, 8'd1, 8'd1, 1'b1, 4'd3},  // R3 miss fires at once
        '{1'b1, 28'hABCDE12, 6'd9, 8'd0, 8'd0, 1'b1, 4'd2}, // R2 page number
        '{1'b1, 28'h21, 6'd63, 8'd1, 8'd65, 1'b0, 4'd8},    // R8 disabled
        '{1'b1, 28'h21, 6'd62, 8'd0, 8'd64, 1'b0, 4'd8}     // R8 needs all lines
    };

    task automatic check(input bit exp, input logic [PW-1:0] page, input int req);
        n_checks++;
        if (pf_valid !== exp || (exp && pf_page !== page)) begin
            n_fails++;
            $display("FAIL R%0d: pf_valid=%0b pf_page=%h expected pf_valid=%0b pf_page=%h",
                     req, pf_valid, pf_page, exp, page);
        end
    endtask

    // Drive one access before an edge, sample 1 ns after it.
    task automatic access(input bit vld, input logic [PW-1:0] page, input logic [5:0] line,
                          input logic [7:0] at, input logic [7:0] uat, input bit exp, input int req);
        @(negedge clk);
        req_valid = vld;
        req_line_addr = {page, line};
        cfg_total_thr = at;
        cfg_unique_thr = uat;
        @(posedge clk);
        #1;
        check(exp, page, req);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        #1;
        check(1'b0, '0, 1);  // R1 reset state

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].vld, VECS[i].page, VECS[i].line, VECS[i].at, VECS[i].uat,
                   VECS[i].exp, int'(VECS[i].req));
        end

        // R8: threshold 64 met only on the last untouched line of page 0x22.
        for (int l = 0; l < 64; l++) begin
            access(1'b1, 28'h22, 6'(l), 8'd0, 8'd64, (l == 63), 8);
        end

        // R5: 300 accesses with prefetch disabled, then the count must still read 255.
        for (int k = 0; k < 300; k++) begin
            access(1'b1, 28'h30, 6'd0, 8'd255, 8'd65, 1'b0, 5);
        end
        access(1'b1, 28'h30, 6'd1, 8'd255, 8'd1, 1'b1, 5);

        // R1: history built before a reset is gone afterwards.
        access(1'b1, 28'h40, 6'd0, 8'd3, 8'd1, 1'b0, 1);
        access(1'b1, 28'h40, 6'd1, 8'd3, 8'd1, 1'b0, 1);
        do_reset();
        #1;
        check(1'b0, '0, 1);
        access(1'b1, 28'h40, 6'd2, 8'd3, 8'd1, 1'b0, 1);

        // R7: fill the table, then check the replacement order.
        do_reset();
        for (int p = 0; p < 16; p++) begin
            access(1'b1, 28'h100 + PW'(p), 6'd0, 8'd3, 8'd1, 1'b0, 7);
        end
        access(1'b1, 28'h100, 6'd0, 8'd3, 8'd1, 1'b0, 7);  // 0x101 becomes oldest
        access(1'b1, 28'h110, 6'd0, 8'd3, 8'd1, 1'b0, 7);  // evicts 0x101
        access(1'b1, 28'h101, 6'd0, 8'd3, 8'd1, 1'b0, 7);  // re-allocated, evicts 0x102
        access(1'b1, 28'h100, 6'd0, 8'd3, 8'd1, 1'b1, 7);  // 0x100 survived
        access(1'b1, 28'h101, 6'd0, 8'd3, 8'd1, 1'b0, 7);  // count restarted at 1, now 2
        access(1'b1, 28'h103, 6'd0, 8'd3, 8'd1, 1'b0, 7);
        access(1'b1, 28'h103, 6'd0, 8'd3, 8'd1, 1'b1, 7);  // 0x103 survived
        access(1'b1, 28'h102, 6'd0, 8'd3, 8'd1, 1'b0, 7);  // evicted, starts over
        access(1'b1, 28'h102, 6'd0, 8'd3, 8'd1, 1'b0, 7);
        access(1'b1, 28'h100, 6'd0, 8'd3, 8'd1, 1'b0, 6);  // R6 invalidated after firing

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, actual hung, expected done");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule